// File: doc/BRIEF.md
# Page-Aligned Program Splitter

This block sits between a host that wants to store an arbitrary run of bytes in serial flash and the command sequencer that performs page-program operations. The host hands over a start address, a byte count and then the bytes themselves as a stream. The block divides the run into program chunks, each of which stays inside one flash page of 2**PAGE_BITS bytes (256 by default). It offers each chunk to the sequencer as an address and length, and then forwards exactly that many bytes. It does not offer the next chunk until the sequencer reports that the chunk has completed.

Only the first chunk can start in the middle of a page. It runs up to the next page boundary. Every later chunk starts on a boundary and is a full page, except for the final one, which carries whatever is left. Before any chunk is issued, the request is screened. A request of zero bytes completes at once and writes nothing. A request that would run past the end of the device is refused. When the request finishes, the block raises a one-cycle completion pulse carrying a status code and the number of data bytes the sequencer has confirmed as programmed.

The sequencer handles readiness polling, the write-enable step and the serial signalling for each chunk. This block handles only the division into chunks and the flow of bytes.

Top module: `pgw_splitter`

## Requirements
- R1: Every offered chunk has a length of at least 1. Its page offset (chk_addr mod 2**PAGE_BITS) plus chk_len is at most 2**PAGE_BITS, so no chunk crosses a page boundary.
- R2: When (start mod 256) + length <= 256, exactly one chunk is issued, at the start address, carrying the full length.
- R3: Otherwise the first chunk is 256 - (start mod 256) bytes long. Each later chunk is min(remaining, 256) bytes at start + bytes already issued.
- R4: chk_valid, chk_addr and chk_len stay unchanged until chk_ready is seen. Exactly chk_len bytes are then forwarded in order on dout_data. The next chunk is offered only after a seq_done pulse for the current one.
- R5: din_ready is high only while the bytes of a chunk are being forwarded, and only when dout_ready is high. Each byte taken from din_data appears unchanged on dout_data in the same cycle.
- R6: A request of length 0 produces no chunk and, in the cycle after acceptance, a completion with status 0 and count 0. This holds even when the address lies outside the device.
- R7: A request with start + length > DEV_BYTES produces no chunk and completes with status 1 and count 0. A request that ends exactly at DEV_BYTES is accepted.
- R8: wr_count equals the sum of chk_len over chunks completed with seq_done and seq_err low. On success with status 0, it equals the requested length.
- R9: A seq_done pulse with seq_err high ends the request. The completion carries status 2, no further chunk is offered, and the count covers only the chunks completed earlier.
- R10: wr_done is a single-cycle pulse. req_ready is high only when the block is idle, so a request presented while a transfer is in flight is not taken.
- R11: After reset, req_ready is 1 and chk_valid, din_ready and wr_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host presents a write request |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of bytes to write |
| din_valid | input | 1 | Host data byte valid |
| din_ready | output | 1 | Block takes the host byte |
| din_data | input | DATA_W | Host data byte |
| chk_valid | output | 1 | Chunk offered to the sequencer |
| chk_ready | input | 1 | Sequencer accepts the chunk |
| chk_addr | output | ADDR_W | Chunk start address |
| chk_len | output | PAGE_BITS+1 | Chunk length in bytes |
| dout_valid | output | 1 | Forwarded byte valid |
| dout_ready | input | 1 | Sequencer takes the forwarded byte |
| dout_data | output | DATA_W | Forwarded byte |
| seq_done | input | 1 | Sequencer finished the current chunk |
| seq_err | input | 1 | Qualifies seq_done: the chunk failed |
| wr_done | output | 1 | One-cycle completion pulse |
| wr_status | output | 2 | 0 success, 1 out of range, 2 chunk failed |
| wr_count | output | LEN_W | Data bytes confirmed as programmed |

## Verification
The bench aims at the lengths that sit on either side of a page boundary. A run that ends exactly on a boundary must produce one chunk, and one byte more must add a one-byte chunk. A design that compares with < where it should use <= would emit a zero-length chunk or spill over into the next page. The bench also starts runs one byte before a boundary, which checks that a one-byte head chunk is followed by full pages and not by a second short chunk.

At the device end, the bench checks both an exact fit and an overrun by one byte; an off-by-one bound would refuse the first or program past the end. It presents a zero-length request at an out-of-range address, which a design that screens the range first would wrongly refuse. It injects failures on the first and later chunks, where a design that counts bytes on forwarding and not on confirmation would over-report.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_XFER,
      ST_WAIT,
      ST_DONE
   } pgw_state_e;

   typedef enum logic [1:0] {
      WR_OK     = 2'd0,
      WR_REJECT = 2'd1,
      WR_FAIL   = 2'd2
   } pgw_status_e;

endpackage

// File: rtl/pgw_chunk_calc.sv
// Length of the next program chunk: the bytes left, clipped at the page end.
module pgw_chunk_calc #(
   parameter int PAGE_BITS = 8,
   parameter int LEN_W     = 16
) (
   input  logic [PAGE_BITS-1:0] page_off,
   input  logic [LEN_W-1:0]     remain,
   output logic [PAGE_BITS:0]   chunk_len
);
   localparam int CL_W = PAGE_BITS + 1;
   localparam int CW   = (LEN_W > CL_W) ? LEN_W : CL_W;

   logic [CL_W-1:0] room;
   logic [CW-1:0]   remain_x;
   logic [CW-1:0]   room_x;
   logic            fits;

   // Bytes from the offset up to the next boundary: 1 .. 2**PAGE_BITS
   assign room = (CL_W'(1) << PAGE_BITS) - {1'b0, page_off};

   generate
      if (LEN_W >= CL_W) begin : g_wide_len
         assign remain_x = remain;
         assign room_x   = CW'(room);
      end else begin : g_narrow_len
         assign remain_x = CW'(remain);
         assign room_x   = room;
      end
   endgenerate

   assign fits      = (remain_x <= room_x);
   assign chunk_len = fits ? CL_W'(remain_x) : room;

endmodule

// File: rtl/pgw_range_chk.sv
// Screens a request against the device size. Meaningful only for length > 0.
module pgw_range_chk #(
   parameter int              ADDR_W    = 24,
   parameter int              LEN_W     = 16,
   parameter longint unsigned DEV_BYTES = 64'd1 << 20
) (
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  length,
   output logic              in_range
);
   localparam int SW       = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;
   localparam int DEV_LOG2 = $clog2(DEV_BYTES);
   localparam bit DEV_POW2 = ((64'd1 << DEV_LOG2) == DEV_BYTES);

   logic [SW-1:0] end_excl;

   assign end_excl = SW'(start_addr) + SW'(length);

   generate
      if (DEV_POW2) begin : g_pow2
         // The last byte touched must have no bits at or above the size bit
         logic [SW-1:0] last_byte;
         assign last_byte = end_excl - SW'(1);
         assign in_range  = ((last_byte >> DEV_LOG2) == '0);
      end else begin : g_any
         assign in_range = (end_excl <= SW'(DEV_BYTES));
      end
   endgenerate

endmodule

// File: rtl/pgw_splitter.sv
module pgw_splitter
   import pgw_pkg::*;
#(
   parameter int              ADDR_W    = 24,
   parameter int              LEN_W     = 16,
   parameter int              DATA_W    = 8,
   parameter int              PAGE_BITS = 8,
   parameter longint unsigned DEV_BYTES = 64'd1 << 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [LEN_W-1:0]     req_len,
   input  logic                 din_valid,
   output logic                 din_ready,
   input  logic [DATA_W-1:0]    din_data,
   output logic                 chk_valid,
   input  logic                 chk_ready,
   output logic [ADDR_W-1:0]    chk_addr,
   output logic [PAGE_BITS:0]   chk_len,
   output logic                 dout_valid,
   input  logic                 dout_ready,
   output logic [DATA_W-1:0]    dout_data,
   input  logic                 seq_done,
   input  logic                 seq_err,
   output logic                 wr_done,
   output logic [1:0]           wr_status,
   output logic [LEN_W-1:0]     wr_count
);
   localparam int CL_W = PAGE_BITS + 1;

   // Elaboration-time parameter screening
   generate
      if (PAGE_BITS < 1) begin : g_bad_page
         $error("pgw_splitter: PAGE_BITS must be at least 1");
      end
      if (ADDR_W <= PAGE_BITS) begin : g_bad_addr
         $error("pgw_splitter: ADDR_W must exceed PAGE_BITS");
      end
      if (LEN_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("pgw_splitter: LEN_W and DATA_W must be positive");
      end
      if (DEV_BYTES == 0 || DEV_BYTES > (64'd1 << ADDR_W)) begin : g_bad_dev
         $error("pgw_splitter: DEV_BYTES must lie in 1 .. 2**ADDR_W");
      end
   endgenerate

   pgw_state_e        state;
   pgw_status_e       status;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  remain;
   logic [CL_W-1:0]   cur_len;
   logic [CL_W-1:0]   left;
   logic [LEN_W-1:0]  count;
   logic [CL_W-1:0]   next_len;
   logic              req_in_range;
   logic              last_chunk;

   pgw_chunk_calc #(
      .PAGE_BITS (PAGE_BITS),
      .LEN_W     (LEN_W)
   ) u_calc (
      .page_off  (cur_addr[PAGE_BITS-1:0]),
      .remain    (remain),
      .chunk_len (next_len)
   );

   pgw_range_chk #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .DEV_BYTES (DEV_BYTES)
   ) u_range (
      .start_addr (req_addr),
      .length     (req_len),
      .in_range   (req_in_range)
   );

   assign last_chunk = (remain == LEN_W'(cur_len));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         status   <= WR_OK;
         cur_addr <= '0;
         remain   <= '0;
         cur_len  <= '0;
         left     <= '0;
         count    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  cur_addr <= req_addr;
                  remain   <= req_len;
                  count    <= '0;
                  if (req_len == '0) begin
                     status <= WR_OK;
                     state  <= ST_DONE;
                  end else if (!req_in_range) begin
                     status <= WR_REJECT;
                     state  <= ST_DONE;
                  end else begin
                     status <= WR_OK;
                     state  <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (chk_ready) begin
                  cur_len <= next_len;
                  left    <= next_len;
                  state   <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (din_valid && dout_ready) begin
                  left <= left - CL_W'(1);
                  if (left == CL_W'(1)) begin
                     state <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (seq_done) begin
                  if (seq_err) begin
                     status <= WR_FAIL;
                     state  <= ST_DONE;
                  end else begin
                     count    <= count + LEN_W'(cur_len);
                     cur_addr <= cur_addr + ADDR_W'(cur_len);
                     remain   <= remain - LEN_W'(cur_len);
                     state    <= last_chunk ? ST_DONE : ST_ISSUE;
                  end
               end
            end
            ST_DONE: begin
               state <= ST_IDLE;
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready  = (state == ST_IDLE);
   assign chk_valid  = (state == ST_ISSUE);
   assign chk_addr   = cur_addr;
   assign chk_len    = next_len;
   assign din_ready  = (state == ST_XFER) && dout_ready;
   assign dout_valid = (state == ST_XFER) && din_valid;
   assign dout_data  = din_data;
   assign wr_done    = (state == ST_DONE);
   assign wr_status  = status;
   assign wr_count   = count;

endmodule

// File: rtl/pgw_split_chk.sv
module pgw_split_chk #(
   parameter int              ADDR_W    = 24,
   parameter int              LEN_W     = 16,
   parameter int              DATA_W    = 8,
   parameter int              PAGE_BITS = 8,
   parameter longint unsigned DEV_BYTES = 64'd1 << 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [LEN_W-1:0]   req_len,
   input logic               din_valid,
   input logic               din_ready,
   input logic               chk_valid,
   input logic               chk_ready,
   input logic [ADDR_W-1:0]  chk_addr,
   input logic [PAGE_BITS:0] chk_len,
   input logic               dout_valid,
   input logic               dout_ready,
   input logic               wr_done,
   input logic [1:0]         wr_status,
   input logic [LEN_W-1:0]   wr_count
);
   localparam int PAGE = 1 << PAGE_BITS;

   // R1
   chunk_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |-> (chk_len != '0) &&
                    (int'(chk_addr[PAGE_BITS-1:0]) + int'(chk_len) <= PAGE));

   // R4
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid && !chk_ready |=> chk_valid && $stable(chk_addr) && $stable(chk_len));

   // R5
   din_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      din_ready |-> dout_ready && (din_valid == dout_valid));

   // R6
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && (req_len == '0) |=>
         wr_done && (wr_status == 2'd0) && (wr_count == '0));

   // R7
   reject_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done && (wr_status == 2'd1) |-> (wr_count == '0));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

   // R10
   idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !chk_valid && !din_ready && !wr_done);

endmodule

bind pgw_splitter pgw_split_chk #(
   .ADDR_W    (ADDR_W),
   .LEN_W     (LEN_W),
   .DATA_W    (DATA_W),
   .PAGE_BITS (PAGE_BITS),
   .DEV_BYTES (DEV_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_len    (req_len),
   .din_valid  (din_valid),
   .din_ready  (din_ready),
   .chk_valid  (chk_valid),
   .chk_ready  (chk_ready),
   .chk_addr   (chk_addr),
   .chk_len    (chk_len),
   .dout_valid (dout_valid),
   .dout_ready (dout_ready),
   .wr_done    (wr_done),
   .wr_status  (wr_status),
   .wr_count   (wr_count)
);

// File: tb/sim_pgw_splitter.sv
module sim_pgw_splitter;
   localparam int              ADDR_W    = 24;
   localparam int              LEN_W     = 16;
   localparam int              DATA_W    = 8;
   localparam int              PAGE_BITS = 8;
   localparam int unsigned     PAGE      = 256;
   localparam int unsigned     DEV       = 32'd1 << 20;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic               req_ready;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic [LEN_W-1:0]   req_len = '0;
   logic               din_valid = 1'b0;
   logic               din_ready;
   logic [DATA_W-1:0]  din_data = '0;
   logic               chk_valid;
   logic               chk_ready = 1'b0;
   logic [ADDR_W-1:0]  chk_addr;
   logic [PAGE_BITS:0] chk_len;
   logic               dout_valid;
   logic               dout_ready = 1'b0;
   logic [DATA_W-1:0]  dout_data;
   logic               seq_done = 1'b0;
   logic               seq_err = 1'b0;
   logic               wr_done;
   logic [1:0]         wr_status;
   logic [LEN_W-1:0]   wr_count;

   int errs = 0;
   int checks = 0;

   pgw_splitter #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .DATA_W    (DATA_W),
      .PAGE_BITS (PAGE_BITS),
      .DEV_BYTES (64'd1 << 20)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .din_valid  (din_valid),
      .din_ready  (din_ready),
      .din_data   (din_data),
      .chk_valid  (chk_valid),
      .chk_ready  (chk_ready),
      .chk_addr   (chk_addr),
      .chk_len    (chk_len),
      .dout_valid (dout_valid),
      .dout_ready (dout_ready),
      .dout_data  (dout_data),
      .seq_done   (seq_done),
      .seq_err    (seq_err),
      .wr_done    (wr_done),
      .wr_status  (wr_status),
      .wr_count   (wr_count)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int unsigned base, input int unsigned idx);
      return 8'((base * 13) + (idx * 7) + (idx >> 8));
   endfunction

   // Expected outcome from the requirements: status, count, number of chunks offered
   task automatic plan(input int unsigned a, input int unsigned l, input int fk,
                       output int st, output int unsigned cnt, output int nch);
      int unsigned off;
      int unsigned room;
      int unsigned ln;
      int n;
      st = 0; cnt = 0; nch = 0; off = 0; n = 0;
      if (l == 0) return;
      if (a + l > DEV) begin
         st = 1;
         return;
      end
      while (off < l) begin
         room = PAGE - ((a + off) % PAGE);
         ln = (l - off < room) ? (l - off) : room;
         if (n == fk) begin
            st = 2;
            nch = n + 1;
            return;
         end
         cnt += ln;
         off += ln;
         n++;
      end
      nch = n;
   endtask

   task automatic run_req(input int unsigned a, input int unsigned l, input int fk,
                          input string tag);
      int st_e;
      int unsigned cnt_e;
      int nch_e;
      int unsigned fed;
      int unsigned issued;
      int unsigned rx_left;
      int k;
      int phase;
      int delay;
      int cyc;
      bit done_seen;
      bit busy_ok;
      bit hold_ok;
      bit data_ok;
      bit chunk_ok;
      int unsigned ea;
      int unsigned el;
      int unsigned room;
      plan(a, l, fk, st_e, cnt_e, nch_e);
      fed = 0; issued = 0; rx_left = 0; k = 0; phase = 0; delay = 0; cyc = 0;
      done_seen = 0; busy_ok = 1; hold_ok = 1; data_ok = 1; chunk_ok = 1;

      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = ADDR_W'(a);
      req_len   = LEN_W'(l);
      #1;
      check(req_ready == 1'b1, "R10", {tag, " idle before request"}, req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = '1;
      req_len   = '1;

      while (!done_seen) begin
         if (cyc != 0) @(negedge clk);
         cyc++;
         din_valid  = (fed < l) && ($urandom % 4 != 0);
         din_data   = pat(a, fed);
         dout_ready = (phase == 1) ? ($urandom % 4 != 0) : 1'($urandom % 2);
         chk_ready  = ($urandom % 3 != 0);
         seq_done   = 1'b0;
         seq_err    = 1'b0;
         if (phase == 2) begin
            if (delay == 0) begin
               seq_done = 1'b1;
               seq_err  = (k - 1 == fk);
            end else begin
               delay--;
            end
         end
         #1;
         if (wr_done) begin
            done_seen = 1;
         end else begin
            if (req_ready) busy_ok = 0;
         end
         if (phase != 1 && din_ready) hold_ok = 0;
         if (chk_valid && phase != 0) chunk_ok = 0;
         if (chk_valid && chk_ready && phase == 0) begin
            ea   = a + issued;
            room = PAGE - (ea % PAGE);
            el   = (l - issued < room) ? (l - issued) : room;
            // R2 single chunk, R3 first and later chunks
            check(int'(k) < nch_e, (nch_e == 1) ? "R2" : "R3",
                  {tag, " chunk count so far"}, k + 1, nch_e);
            check(chk_addr == ADDR_W'(ea), (nch_e == 1) ? "R2" : "R3",
                  {tag, " chunk addr"}, chk_addr, ea);
            check(chk_len == 9'(el), (nch_e == 1) ? "R2" : "R3",
                  {tag, " chunk len"}, chk_len, el);
            rx_left = chk_len;
            issued += el;
            k++;
            phase = 1;
         end else if (din_valid && din_ready) begin
            if (!(dout_valid && dout_data == pat(a, fed))) data_ok = 0;
            fed++;
            rx_left--;
            if (rx_left == 0) begin
               phase = 2;
               delay = $urandom % 4;
            end
         end else if (phase == 2 && seq_done) begin
            phase = seq_err ? 3 : 0;
         end
         if (cyc > 40000) begin
            check(0, "R4", {tag, " watchdog, no completion"}, cyc, 40000);
            done_seen = 1;
         end
      end

      // Values seen in the completion cycle
      check(wr_status == 2'(st_e), (st_e == 1) ? "R7" : ((st_e == 2) ? "R9" : "R8"),
            {tag, " status"}, wr_status, st_e);
      check(wr_count == LEN_W'(cnt_e), (st_e == 2) ? "R9" : "R8",
            {tag, " count"}, wr_count, cnt_e);
      check(k == nch_e, (l == 0) ? "R6" : "R4", {tag, " chunks offered"}, k, nch_e);
      check(data_ok, "R4", {tag, " forwarded bytes"}, data_ok, 1);
      check(hold_ok, "R5", {tag, " input held off outside transfer"}, hold_ok, 1);
      check(busy_ok && chunk_ok, "R10", {tag, " busy exclusion"}, busy_ok, 1);
      din_valid  = 1'b0;
      chk_ready  = 1'b0;
      dout_ready = 1'b0;
      seq_done   = 1'b0;
      seq_err    = 1'b0;
      @(negedge clk);
      #1;
      check(!wr_done && req_ready, "R10", {tag, " done is one cycle"}, wr_done, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R11 reset state
      check(req_ready == 1'b1, "R11", "req_ready after reset", req_ready, 1);
      check(chk_valid == 1'b0, "R11", "chk_valid after reset", chk_valid, 0);
      check(din_ready == 1'b0, "R11", "din_ready after reset", din_ready, 0);
      check(wr_done == 1'b0, "R11", "wr_done after reset", wr_done, 0);

      run_req(32'h10, 0, -1, "R6 zero length");
      run_req(32'hFFFFF0, 0, -1, "R6 zero length out of range");
      run_req(DEV - 4, 5, -1, "R7 overrun by one");
      run_req(DEV - 4, 4, -1, "R7 exact end");
      run_req(32'h100, 256, -1, "R2 full page");
      run_req(32'h1F0, 16, -1, "R2 ends on boundary");
      run_req(32'h1F0, 17, -1, "R3 one past boundary");
      run_req(32'h2FF, 600, -1, "R3 one-byte head");
      run_req(32'h310, 700, 1, "R9 second chunk fails");
      run_req(32'h400, 300, 0, "R9 first chunk fails");
      run_req(32'h500, 1, -1, "R1 single byte");

      for (int i = 0; i < 20; i++) begin
         int unsigned a;
         int unsigned l;
         int fk;
         a  = $urandom % DEV;
         l  = 1 + ($urandom % 1100);
         if (i % 5 == 0) a = DEV - ($urandom % 700) - 1;
         fk = ($urandom % 6 == 0) ? int'($urandom % 3) : -1;
         run_req(a, l, fk, "R1 random");
      end

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule